// File: doc/BRIEF.md
# USB Host Data Packet Receiver

This block takes the stream of sampled bus line states that a host port sees after it has issued an IN token, and turns it into payload bytes. Each bit time arrives as a two-bit line code with a qualifying strobe, so the block can run from a clock that is faster than the bus bit rate. The block finds the sync pattern and undoes the NRZI coding. It removes stuffed bits and checks that the packet identifier is DATA0 or DATA1.

The packet's toggle is compared with the toggle that the host expects. Payload bytes reach an endpoint buffer write port only if the two agree. A direction input selects which of two buffer ports receives them. The two trailing CRC bytes are held back and never written. CRC16 is accumulated over the payload and the CRC field, and the verdict is given only when end-of-packet is seen. At that point the block reports the payload byte count and pulses a done flag. The error flags remain readable until the next sync.

Top module: `usb_data_rx`

## Requirements
- R1: Line codes are J = 2'b01, K = 2'b10 and SE0 = 2'b00, with 2'b11 handled as SE0. A bit time is taken only when `bit_vld` is high. A decoded bit is 1 when the level matches the previous non-SE0 level and 0 when it differs. Idle is J. Reception starts only after seven decoded 0s followed by a 1. Before that, no flag, write or done appears.
- R2: After six consecutive decoded 1s (the final sync 1 included), the next bit is dropped if it is 0. If it is 1, `stuff_err` is set and no further write happens for that packet.
- R3: The first byte after sync is the PID, received LSB first. Only 8'hC3 (DATA0, toggle 0) and 8'h4B (DATA1, toggle 1) are accepted. Any other value sets `pid_err` and the packet produces no write.
- R4: PID bit 3 is the received toggle, and it is compared with `exp_tgl` as sampled when the PID completes. On a mismatch `tgl_err` is set and no write occurs, but `byte_cnt` still counts the payload.
- R5: `dir`, sampled when the PID completes, chooses the buffer: 0 writes through `wr_a` and 1 writes through `wr_b`. The two strobes are never high together.
- R6: Payload bytes are written in arrival order at addresses 0, 1, 2 and so on. A byte is written one clock after the bit time that completes the byte two places behind it. `byte_cnt` equals the number of bytes released, and the final two bytes are never written.
- R7: CRC16 uses polynomial 16'h8005 and starts from 16'hFFFF. It is fed LSB first with every data bit after the PID. At end-of-packet `crc_err` is set when the register differs from 16'h800D. It never changes at any other time.
- R8: End-of-packet is two or more SE0 bit times followed by a non-SE0 bit. The `done` pulse lasts one clock and appears in the clock after that bit time.
- R9: At end-of-packet `frm_err` is set if the bits after the PID do not form whole bytes, if fewer than two bytes followed the PID, or if the PID itself was incomplete.
- R10: After reset all outputs are 0. The flags and `byte_cnt` are cleared at sync and hold their values after `done` until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | One pulse per bus bit time |
| line_st | input | 2 | Sampled line code (J, K, SE0) |
| exp_tgl | input | 1 | Expected data toggle |
| dir | input | 1 | Buffer select |
| wr_a | output | 1 | Write strobe, buffer selected by dir = 0 |
| wr_b | output | 1 | Write strobe, buffer selected by dir = 1 |
| wr_addr | output | ADDR_W | Byte address within the buffer |
| wr_data | output | 8 | Byte to write |
| byte_cnt | output | ADDR_W+1 | Payload bytes in the packet |
| done | output | 1 | End-of-packet pulse |
| tgl_err | output | 1 | Toggle mismatch |
| pid_err | output | 1 | PID not DATA0/DATA1 |
| crc_err | output | 1 | CRC residual wrong |
| stuff_err | output | 1 | Seventh consecutive 1 seen |
| frm_err | output | 1 | End-of-packet not on a byte boundary |

## Verification
A single bit time can do two things at once. It can complete a byte, which releases the byte held two places back to a buffer, and it can also close a run of six 1s, so the next bit must be discarded. All-ones payloads and all-ones CRC fields make this happen often, and one variant replaces the expected stuffed 0 with a 1 in the middle of a byte. A behavioural model in the bench checks, clock by clock, that the write still lands with the right address and data. It also checks that the dropped bit shifts neither the next byte nor the CRC, and that an illegal seventh 1 stops every later write.

// File: rtl/usb_data_rx.sv
module usb_data_rx #(
  parameter int          ADDR_W   = 6,
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD = 16'h800D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic [1:0]        line_st,
  input  logic              exp_tgl,
  input  logic              dir,
  output logic              wr_a,
  output logic              wr_b,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W:0]   byte_cnt,
  output logic              done,
  output logic              tgl_err,
  output logic              pid_err,
  output logic              crc_err,
  output logic              stuff_err,
  output logic              frm_err
);
  localparam logic [7:0] PID_D0 = 8'hC3;
  localparam logic [7:0] PID_D1 = 8'h4B;
  localparam logic [2:0] RUN_MAX = 3'd6;
  localparam logic [7:0] SYNC_HIST = 8'h80;

  typedef enum logic [1:0] {S_IDLE, S_PID, S_DATA, S_DROP} st_t;
  st_t st;

  logic        prev_k, match, dsel;
  logic [7:0]  hist, shr, p0, p1;
  logic [2:0]  ones, nbit;
  logic [1:0]  se0n, pend;
  logic [15:0] crc;

  wire is_se0   = (line_st[1] == line_st[0]);
  wire is_k     = (line_st == 2'b10);
  wire dbit     = (is_k == prev_k);
  wire in_pkt   = (st != S_IDLE);
  wire eop      = in_pkt && (se0n >= 2'd2);
  wire [7:0] byte_nx = {dbit, shr[7:1]};
  wire [7:0] hist_nx = {dbit, hist[7:1]};
  wire byte_done = (nbit == 3'd7);
  wire pid_ok   = (byte_nx == PID_D0) || (byte_nx == PID_D1);
  wire [15:0] crc_nx = {crc[14:0], 1'b0} ^ ((crc[15] ^ dbit) ? CRC_POLY : 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      prev_k <= 1'b0;  match <= 1'b0;  dsel <= 1'b0;
      hist <= 8'hFF;   shr <= '0;  p0 <= '0;  p1 <= '0;
      ones <= '0;  nbit <= '0;  se0n <= '0;  pend <= '0;
      crc <= CRC_INIT;
      wr_a <= 1'b0;  wr_b <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
      byte_cnt <= '0;  done <= 1'b0;
      tgl_err <= 1'b0;  pid_err <= 1'b0;  crc_err <= 1'b0;
      stuff_err <= 1'b0;  frm_err <= 1'b0;
    end else begin
      wr_a <= 1'b0;
      wr_b <= 1'b0;
      done <= 1'b0;
      if (bit_vld) begin
        if (is_se0) begin
          if (in_pkt && se0n != 2'd3) se0n <= se0n + 2'd1;
        end else begin
          prev_k <= is_k;
          se0n   <= '0;
          if (eop) begin
            done <= 1'b1;
            st   <= S_IDLE;
            hist <= 8'hFF;
            if (st == S_DATA) begin
              frm_err <= (nbit != 3'd0) || (pend != 2'd2);
              crc_err <= (crc != CRC_GOOD);
            end else if (st == S_PID) begin
              frm_err <= 1'b1;
            end
          end else begin
            unique case (st)
              S_IDLE: begin
                hist <= hist_nx;
                if (hist_nx == SYNC_HIST) begin
                  st <= S_PID;
                  ones <= 3'd1;  nbit <= '0;  pend <= '0;
                  crc <= CRC_INIT;  byte_cnt <= '0;
                  tgl_err <= 1'b0;  pid_err <= 1'b0;  crc_err <= 1'b0;
                  stuff_err <= 1'b0;  frm_err <= 1'b0;
                end
              end
              S_PID, S_DATA: begin
                if (ones == RUN_MAX) begin
                  ones <= '0;
                  if (dbit) begin
                    stuff_err <= 1'b1;
                    st <= S_DROP;
                  end
                end else begin
                  ones <= dbit ? ones + 3'd1 : 3'd0;
                  shr  <= byte_nx;
                  nbit <= nbit + 3'd1;
                  if (st == S_DATA) crc <= crc_nx;
                  if (byte_done) begin
                    if (st == S_PID) begin
                      if (pid_ok) begin
                        st <= S_DATA;
                        match <= (byte_nx[3] == exp_tgl);
                        tgl_err <= (byte_nx[3] != exp_tgl);
                        dsel <= dir;
                      end else begin
                        pid_err <= 1'b1;
                        st <= S_DROP;
                      end
                    end else begin
                      p1 <= byte_nx;
                      p0 <= p1;
                      if (pend == 2'd2) begin
                        wr_a <= match & ~dsel;
                        wr_b <= match & dsel;
                        wr_data <= p0;
                        wr_addr <= byte_cnt[ADDR_W-1:0];
                        byte_cnt <= byte_cnt + 1'b1;
                      end else begin
                        pend <= pend + 2'd1;
                      end
                    end
                  end
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_data_rx_chk.sv
module usb_data_rx_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              wr_a,
  input logic              wr_b,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W:0]   byte_cnt,
  input logic              done,
  input logic              tgl_err,
  input logic              pid_err,
  input logic              crc_err,
  input logic              stuff_err,
  input logic              frm_err
);
  a_r5_one_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_a && wr_b));

  a_r4_write_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a || wr_b) |-> (!tgl_err && !pid_err && !stuff_err));

  a_r6_addr_follows_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a || wr_b) |-> (byte_cnt[ADDR_W-1:0] == wr_addr + 1'b1));

  a_r6_write_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a || wr_b) |-> $past(bit_vld));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_paced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_vld));

  a_r7_crc_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> done);

  a_r9_frm_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> done);
endmodule

bind usb_data_rx usb_data_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .wr_a(wr_a), .wr_b(wr_b),
  .wr_addr(wr_addr), .byte_cnt(byte_cnt), .done(done), .tgl_err(tgl_err),
  .pid_err(pid_err), .crc_err(crc_err), .stuff_err(stuff_err), .frm_err(frm_err)
);

// File: tb/usb_data_rx_tb.sv
module usb_data_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, bit_vld = 1'b0, exp_tgl = 1'b0, dir = 1'b0;
  logic [1:0] line_st = 2'b01;
  logic wr_a, wr_b, done, tgl_err, pid_err, crc_err, stuff_err, frm_err;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [ADDR_W:0] byte_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_data_rx #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_st(line_st),
    .exp_tgl(exp_tgl), .dir(dir), .wr_a(wr_a), .wr_b(wr_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .byte_cnt(byte_cnt), .done(done), .tgl_err(tgl_err),
    .pid_err(pid_err), .crc_err(crc_err), .stuff_err(stuff_err), .frm_err(frm_err));

  int nvec = 0, nerr = 0;
  bit finished = 0, run_cmp = 0;

  task automatic chk(input string req, input int act, input int expv);
    nvec++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit d);
    return {c[14:0], 1'b0} ^ ((c[15] ^ d) ? 16'h8005 : 16'h0000);
  endfunction

  // reference model
  int m_st, m_zrun, m_se0, m_ones, m_nb, e_cnt, e_waddr;
  bit m_prevk, m_match, m_dsel;
  bit e_wa, e_wb, e_done, e_tgl, e_pid, e_crc, e_stf, e_frm;
  logic [7:0] m_cur, e_wdata;
  logic [7:0] m_pend[$];
  logic [15:0] m_crc;

  task automatic model_bit(input logic [1:0] ls);
    bit se0, k, d;
    logic [7:0] b;
    se0 = (ls == 2'b00) || (ls == 2'b11);
    k = (ls == 2'b10);
    if (se0) begin
      if (m_st != 0) m_se0++;
      return;
    end
    d = (k == m_prevk);
    m_prevk = k;
    if (m_st != 0 && m_se0 >= 2) begin
      e_done = 1;
      if (m_st == 2) begin
        e_frm = (m_nb != 0) || (m_pend.size() != 2);
        e_crc = (m_crc != 16'h800D);
      end else if (m_st == 1) e_frm = 1;
      m_st = 0; m_zrun = 0; m_se0 = 0;
      return;
    end
    m_se0 = 0;
    if (m_st == 0) begin
      if (d && m_zrun >= 7) begin
        m_st = 1; m_ones = 1; m_nb = 0; m_pend.delete(); m_crc = 16'hFFFF; e_cnt = 0;
        e_tgl = 0; e_pid = 0; e_crc = 0; e_stf = 0; e_frm = 0;
      end
      m_zrun = d ? 0 : m_zrun + 1;
    end else if (m_st == 1 || m_st == 2) begin
      if (m_ones == 6) begin
        if (d) begin e_stf = 1; m_st = 3; end
        m_ones = 0;
      end else begin
        m_ones = d ? m_ones + 1 : 0;
        m_cur = {d, m_cur[7:1]};
        m_nb++;
        if (m_st == 2) m_crc = crc_step(m_crc, d);
        if (m_nb == 8) begin
          m_nb = 0;
          if (m_st == 1) begin
            if (m_cur == 8'hC3 || m_cur == 8'h4B) begin
              m_st = 2; m_match = (m_cur[3] == exp_tgl); e_tgl = !m_match; m_dsel = dir;
            end else begin e_pid = 1; m_st = 3; end
          end else begin
            m_pend.push_back(m_cur);
            if (m_pend.size() == 3) begin
              b = m_pend.pop_front();
              e_wa = m_match && !m_dsel; e_wb = m_match && m_dsel;
              e_wdata = b; e_waddr = e_cnt % (1 << ADDR_W); e_cnt++;
            end
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_zrun = 0; m_se0 = 0; m_ones = 0; m_nb = 0; m_prevk = 0;
      m_pend.delete(); m_crc = 16'hFFFF; m_cur = 0;
      e_wa = 0; e_wb = 0; e_done = 0; e_tgl = 0; e_pid = 0; e_crc = 0; e_stf = 0; e_frm = 0;
      e_cnt = 0; e_waddr = 0; e_wdata = 0;
    end else begin
      e_wa = 0; e_wb = 0; e_done = 0;
      if (bit_vld) model_bit(line_st);
    end
  end

  // capture of writes for packet-level checks
  logic [7:0] cap_a[$], cap_b[$];
  int dn_cnt;

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R5 wr_a", wr_a, e_wa);
      chk("R5 wr_b", wr_b, e_wb);
      if (e_wa || e_wb) begin
        chk("R6 wr_data", wr_data, e_wdata);
        chk("R6 wr_addr", wr_addr, e_waddr);
      end
      chk("R6 byte_cnt", byte_cnt, e_cnt);
      chk("R8 done", done, e_done);
      chk("R4 tgl_err", tgl_err, e_tgl);
      chk("R3 pid_err", pid_err, e_pid);
      chk("R7 crc_err", crc_err, e_crc);
      chk("R2 stuff_err", stuff_err, e_stf);
      chk("R9 frm_err", frm_err, e_frm);
      if (wr_a) cap_a.push_back(wr_data);
      if (wr_b) cap_b.push_back(wr_data);
      if (done) dn_cnt++;
    end
  end

  logic [7:0] tx_pl[$];

  task automatic put_sym(input logic [1:0] s, input int gap);
    @(negedge clk);
    line_st = s;
    bit_vld = 1'b1;
    for (int g = 1; g < gap; g++) begin
      @(negedge clk);
      bit_vld = 1'b0;
    end
  endtask

  task automatic finish_pkt(input int gap);
    put_sym(2'b00, gap); put_sym(2'b00, gap); put_sym(2'b01, gap);
    for (int i = 0; i < 4; i++) put_sym(2'b01, gap);
    @(negedge clk);
    bit_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] pid, input bit tgl, input bit dsel, input int gap,
                          input bit bad_crc, input bit break_stf, input bit no_crc, input int extra);
    bit dbits[$];
    logic [15:0] c;
    bit lvl_k, broke;
    int ones;
    @(negedge clk);
    exp_tgl = tgl; dir = dsel;
    cap_a.delete(); cap_b.delete(); dn_cnt = 0;
    for (int i = 0; i < 7; i++) dbits.push_back(1'b0);
    dbits.push_back(1'b1);
    for (int i = 0; i < 8; i++) dbits.push_back(pid[i]);
    c = 16'hFFFF;
    foreach (tx_pl[j])
      for (int i = 0; i < 8; i++) begin
        dbits.push_back(tx_pl[j][i]);
        c = crc_step(c, tx_pl[j][i]);
      end
    if (bad_crc) c ^= 16'h0100;
    if (!no_crc) for (int i = 15; i >= 0; i--) dbits.push_back(~c[i]);
    for (int i = 0; i < extra; i++) dbits.push_back(1'b0);
    lvl_k = 0; ones = 0; broke = 0;
    foreach (dbits[i]) begin
      if (!dbits[i]) lvl_k = !lvl_k;
      put_sym(lvl_k ? 2'b10 : 2'b01, gap);
      ones = dbits[i] ? ones + 1 : 0;
      if (ones == 6) begin
        if (break_stf && !broke && i >= 16) broke = 1;
        else lvl_k = !lvl_k;
        put_sym(lvl_k ? 2'b10 : 2'b01, gap);
        ones = 0;
      end
    end
    finish_pkt(gap);
  endtask

  // which: 0 none, 1 buffer A, 2 buffer B; -1 skips a flag
  task automatic post(input string tag, input int which, input int cnt,
                      input int t, input int p, input int c, input int s, input int f);
    chk({tag, " R8 one done"}, dn_cnt, 1);
    chk({tag, " R6 byte_cnt"}, byte_cnt, cnt);
    if (t >= 0) chk({tag, " R4 tgl_err"}, tgl_err, t);
    if (p >= 0) chk({tag, " R3 pid_err"}, pid_err, p);
    if (c >= 0) chk({tag, " R7 crc_err"}, crc_err, c);
    if (s >= 0) chk({tag, " R2 stuff_err"}, stuff_err, s);
    if (f >= 0) chk({tag, " R9 frm_err"}, frm_err, f);
    chk({tag, " R5 buffer A count"}, cap_a.size(), which == 1 ? cnt : 0);
    chk({tag, " R5 buffer B count"}, cap_b.size(), which == 2 ? cnt : 0);
    for (int i = 0; i < cnt; i++) begin
      if (which == 1 && i < cap_a.size()) chk({tag, " R6 byte A"}, cap_a[i], tx_pl[i]);
      if (which == 2 && i < cap_b.size()) chk({tag, " R6 byte B"}, cap_b[i], tx_pl[i]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nerr++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 reset wr", {wr_a, wr_b}, 0);
    chk("R10 reset flags", {done, tgl_err, pid_err, crc_err, stuff_err, frm_err}, 0);
    chk("R10 reset byte_cnt", byte_cnt, 0);
    run_cmp = 1;
    for (int i = 0; i < 5; i++) put_sym(2'b01, 1);

    // R1: five zeros then a one, not a sync, then end pattern
    dn_cnt = 0;
    begin
      bit lk = 0;
      for (int i = 0; i < 5; i++) begin lk = !lk; put_sym(lk ? 2'b10 : 2'b01, 1); end
      put_sym(lk ? 2'b10 : 2'b01, 1);
      for (int i = 0; i < 3; i++) put_sym(2'b01, 1);
    end
    finish_pkt(1);
    chk("R1 no done without sync", dn_cnt, 0);
    chk("R1 no flags without sync", {tgl_err, pid_err, crc_err, stuff_err, frm_err}, 0);

    tx_pl = '{8'h12, 8'hA5, 8'h00, 8'h7E};
    send_pkt(8'hC3, 0, 0, 1, 0, 0, 0, 0);
    post("DATA0 dir0", 1, 4, 0, 0, 0, 0, 0);

    tx_pl = '{8'h3C, 8'h81, 8'hF0};
    send_pkt(8'h4B, 1, 1, 3, 0, 0, 0, 0);
    post("DATA1 dir1 gap", 2, 3, 0, 0, 0, 0, 0);

    tx_pl = '{8'h55, 8'h66};
    send_pkt(8'h4B, 0, 0, 1, 0, 0, 0, 0);
    post("toggle mismatch", 0, 2, 1, 0, 0, 0, 0);

    tx_pl = '{8'h11};
    send_pkt(8'hC2, 0, 0, 1, 0, 0, 0, 0);
    post("bad pid", 0, 0, 0, 1, 0, 0, 0);

    tx_pl = '{8'h11};
    send_pkt(8'h69, 0, 0, 1, 0, 0, 0, 0);
    post("non-data pid", 0, 0, 0, 1, 0, 0, 0);

    tx_pl = '{8'h01, 8'h02, 8'h03};
    send_pkt(8'hC3, 0, 1, 2, 1, 0, 0, 0);
    post("bad crc", 2, 3, 0, 0, 1, 0, 0);

    tx_pl = '{8'hFF, 8'hFF, 8'hFE, 8'hFF, 8'h3F};
    send_pkt(8'hC3, 0, 0, 1, 0, 0, 0, 0);
    post("R2 stuffed ones", 1, 5, 0, 0, 0, 0, 0);

    tx_pl = '{8'hFF, 8'h00, 8'h00};
    send_pkt(8'hC3, 0, 0, 1, 0, 1, 0, 0);
    post("R2 stuff violation", 0, 0, 0, 0, -1, 1, -1);

    tx_pl = '{8'h9A, 8'hBC};
    send_pkt(8'h4B, 1, 0, 1, 0, 0, 0, 3);
    post("R9 off boundary", 1, 2, 0, 0, -1, 0, 1);

    tx_pl = {};
    send_pkt(8'hC3, 0, 1, 1, 0, 0, 0, 0);
    post("R7 empty payload", 0, 0, 0, 0, 0, 0, 0);

    tx_pl = '{8'h5A};
    send_pkt(8'hC3, 0, 0, 1, 0, 0, 1, 0);
    post("R9 short packet", 0, 0, 0, 0, -1, 0, 1);

    // R10 flags hold after done
    repeat (5) @(negedge clk);
    chk("R10 frm_err held", frm_err, 1);

    tx_pl = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00, 8'hFF};
    send_pkt(8'h4B, 1, 1, 1, 0, 0, 0, 0);
    post("R10 cleared at sync", 2, 6, 0, 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule